// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns one read or write request from the core into the strobe sequence of a microcontroller-style external memory bus. Each request produces an active-low address strobe, then an active-low data strobe, with a read/write level, an address output enable and a write-data output enable around them. One clock of the block equals one oscillator period. Every phase length follows from a clock prescale value P and a wait-state count W, using the formulas given in the requirements below. These two values are sampled together with the request.

The core raises `req` with direction, address, write data and the P/W setting, and holds them until `ack` pulses. On reads the block samples the external data bus on the clock edge that ends the data strobe, and returns that byte on `rdata` when it raises `ack`. An external `bus_wait` input can stretch the data strobe while the strobe is early in its low phase.

Top module: `ext_bus_seq`

## Requirements
- R1: While `rst` is high and after it, with no request, `bus_as_n` and `bus_ds_n` are 1, `bus_addr_oe`, `bus_wdata_oe` and `ack` are 0.
- R2: A cycle starts with `bus_as_n` low for exactly 2P+1 clocks. During that time `bus_addr_oe` is 1, `bus_addr` holds the request address and `bus_rd` is 1 for a read and 0 for a write.
- R3: Exactly one clock with both strobes high separates the rise of `bus_as_n` from the fall of `bus_ds_n`. The two strobes are never low together, and `bus_addr_oe` stays 1 in that gap.
- R4: On a read with `bus_wait` low, `bus_ds_n` stays low for exactly 4P+2W+3 clocks.
- R5: On a write with `bus_wait` low, `bus_ds_n` stays low for exactly 2P+2W+2 clocks. `bus_wdata_oe` is 1 with the request data from the first address-strobe clock through the clock after `bus_ds_n` rises. It is 0 in every read cycle and while idle.
- R6: Count data-strobe clocks from 0 at the fall of `bus_ds_n`, and do not advance the count on a stretched clock. Each clock in which `bus_wait` is 1 while that count is at most 2W adds one clock to the data-strobe low time. `bus_wait` at any other time has no effect.
- R7: On a read, the byte on `bus_rdata_in` at the clock edge where `bus_ds_n` rises is returned on `rdata` while `ack` is 1.
- R8: `bus_addr_oe` is 0 while `bus_ds_n` is low on a read. It is 1 while `bus_ds_n` is low on a write. It is 0 in the clock after `bus_ds_n` rises and while idle.
- R9: Exactly one clock with both strobes high follows the rise of `bus_ds_n`. `ack` is then 1 for exactly one clock. A request still held high during the `ack` clock does not start a new cycle at the edge that ends it.
- R10: P, W, direction, address and write data are taken only at the edge that accepts the request. Changing those inputs later in the cycle does not alter its timing or values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Core request, held until ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| cfg_pre | input | PW | Prescale value P |
| cfg_wait | input | WW | Wait-state count W |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | DW | Captured read data |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_rd | output | 1 | Direction level, 1 = read |
| bus_addr | output | AW | Address to the bus |
| bus_addr_oe | output | 1 | Address output enable |
| bus_wdata | output | DW | Write data to the bus |
| bus_wdata_oe | output | 1 | Write-data output enable |
| bus_rdata_in | input | DW | Data bus read input |
| bus_wait | input | 1 | External stretch request, active high |

## Verification
The stretch logic and the end-of-strobe decision can land on the same clock. This happens when `bus_wait` is raised on the data-strobe clock whose count equals exactly 2W, which is the last point inside the window. The bench drives a wait burst that starts there, one that starts a clock later, and one that starts at count 0. It predicts the strobe length from the rule in R6. Read data is driven with its complement outside the low strobe, so a capture one edge early or late returns the wrong byte.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_AS,
        PH_GAP,
        PH_DS,
        PH_END
    } phase_e;

    function automatic int as_cycles(int p);
        return 2 * p + 1;
    endfunction

    function automatic int ds_cycles(bit is_write, int p, int w);
        if (is_write)
            return 2 * p + 2 * w + 2;
        return 4 * p + 2 * w + 3;
    endfunction

    function automatic int max_len(int pw, int ww);
        return 4 * ((1 << pw) - 1) + 2 * ((1 << ww) - 1) + 3;
    endfunction

endpackage

// File: rtl/ebs_phase_fsm.sv
module ebs_phase_fsm #(
    parameter int PW = 3,
    parameter int WW = 3,
    parameter int CW = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            is_write,
    input  logic [PW-1:0]   pre,
    input  logic [WW-1:0]   wt,
    input  logic            wait_in,
    output ebs_pkg::phase_e phase,
    output logic            ds_final,
    output logic            ack
);
    import ebs_pkg::*;

    phase_e        ph_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len;
    logic [CW-1:0] win_end;
    logic          stall;
    logic          last;
    logic          ack_q;

    always_comb begin
        case (ph_q)
            PH_AS:   len = CW'(as_cycles(int'(pre)));
            PH_DS:   len = CW'(ds_cycles(is_write, int'(pre), int'(wt)));
            default: len = CW'(1);
        endcase
    end

    assign win_end = CW'(2 * int'(wt));
    assign stall   = (ph_q == PH_DS) && wait_in && (cnt_q <= win_end);
    assign last    = !stall && (cnt_q == len - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
            ack_q <= 1'b0;
        end else begin
            ack_q <= (ph_q == PH_END) && last;
            case (ph_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (start) ph_q <= PH_AS;
                end
                default: begin
                    if (stall) begin
                        cnt_q <= cnt_q;
                    end else if (last) begin
                        cnt_q <= '0;
                        case (ph_q)
                            PH_AS:   ph_q <= PH_GAP;
                            PH_GAP:  ph_q <= PH_DS;
                            PH_DS:   ph_q <= PH_END;
                            default: ph_q <= PH_IDLE;
                        endcase
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
            endcase
        end
    end

    assign phase    = ph_q;
    assign ds_final = (ph_q == PH_DS) && last;
    assign ack      = ack_q;

endmodule

// File: rtl/ebs_pin_decode.sv
module ebs_pin_decode (
    input  ebs_pkg::phase_e phase,
    input  logic            is_write,
    output logic            as_n,
    output logic            ds_n,
    output logic            addr_oe,
    output logic            wdata_oe
);
    import ebs_pkg::*;

    always_comb begin
        as_n     = (phase != PH_AS);
        ds_n     = (phase != PH_DS);
        addr_oe  = (phase == PH_AS) || (phase == PH_GAP) ||
                   ((phase == PH_DS) && is_write);
        wdata_oe = is_write && (phase != PH_IDLE);
    end

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int PW = 3,
    parameter int WW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [PW-1:0] cfg_pre,
    input  logic [WW-1:0] cfg_wait,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic          bus_as_n,
    output logic          bus_ds_n,
    output logic          bus_rd,
    output logic [AW-1:0] bus_addr,
    output logic          bus_addr_oe,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_wdata_oe,
    input  logic [DW-1:0] bus_rdata_in,
    input  logic          bus_wait
);
    import ebs_pkg::*;

    localparam int MAXLEN = max_len(PW, WW);
    localparam int CW     = $clog2(MAXLEN + 1);

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic [PW-1:0] pre;
        logic [WW-1:0] wt;
    } req_t;

    req_t          lat_q;
    logic [DW-1:0] rdata_q;
    phase_e        phase;
    logic          ds_final;
    logic          ack_i;
    logic          accept;

    assign accept = req && (phase == PH_IDLE) && !ack_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                lat_q.wr   <= req_write;
                lat_q.addr <= req_addr;
                lat_q.wd   <= req_wdata;
                lat_q.pre  <= cfg_pre;
                lat_q.wt   <= cfg_wait;
            end
            if (ds_final && !lat_q.wr)
                rdata_q <= bus_rdata_in;
        end
    end

    ebs_phase_fsm #(
        .PW(PW),
        .WW(WW),
        .CW(CW)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .is_write(lat_q.wr),
        .pre     (lat_q.pre),
        .wt      (lat_q.wt),
        .wait_in (bus_wait),
        .phase   (phase),
        .ds_final(ds_final),
        .ack     (ack_i)
    );

    ebs_pin_decode u_pins (
        .phase   (phase),
        .is_write(lat_q.wr),
        .as_n    (bus_as_n),
        .ds_n    (bus_ds_n),
        .addr_oe (bus_addr_oe),
        .wdata_oe(bus_wdata_oe)
    );

    assign ack       = ack_i;
    assign rdata     = rdata_q;
    assign bus_rd    = !lat_q.wr;
    assign bus_addr  = lat_q.addr;
    assign bus_wdata = lat_q.wd;

endmodule

// File: rtl/ebs_checker.sv
module ebs_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          as_n,
    input logic          ds_n,
    input logic          rd,
    input logic          addr_oe,
    input logic          wdata_oe,
    input logic          ack,
    input logic [AW-1:0] addr
);

    p_strobes_apart_r3: assert property (@(posedge clk) disable iff (rst)
        !(!as_n && !ds_n));

    p_gap_before_ds_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(ds_n) |-> ($past(as_n) && !$past(as_n, 2)));

    p_tail_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ds_n) |-> (as_n && !ack) ##1 (as_n && ack));

    p_ack_single_r9: assert property (@(posedge clk) disable iff (rst)
        ack |=> (!ack && as_n));

    p_wdata_only_write_r5: assert property (@(posedge clk) disable iff (rst)
        wdata_oe |-> !rd);

    p_addr_release_r8: assert property (@(posedge clk) disable iff (rst)
        (!ds_n && rd) |-> !addr_oe);

    p_hold_in_ds_r10: assert property (@(posedge clk) disable iff (rst)
        !ds_n |-> ($stable(rd) && $stable(addr)));

endmodule

bind ext_bus_seq ebs_checker #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .as_n    (bus_as_n),
    .ds_n    (bus_ds_n),
    .rd      (bus_rd),
    .addr_oe (bus_addr_oe),
    .wdata_oe(bus_wdata_oe),
    .ack     (ack),
    .addr    (bus_addr)
);

// File: tb/ext_bus_seq_test.sv
module ext_bus_seq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [2:0]  cfg_pre = '0;
    logic [2:0]  cfg_wait = '0;
    logic        ack;
    logic [7:0]  rdata;
    logic        bus_as_n, bus_ds_n, bus_rd, bus_addr_oe, bus_wdata_oe;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata_in = '0;
    logic        bus_wait = 1'b0;

    always #10 clk = ~clk;

    ext_bus_seq uut (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_pre(cfg_pre),
        .cfg_wait(cfg_wait), .ack(ack), .rdata(rdata),
        .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe),
        .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe),
        .bus_rdata_in(bus_rdata_in), .bus_wait(bus_wait)
    );

    typedef struct {
        bit          wr;
        logic [15:0] addr;
        logic [7:0]  wd;
        logic [7:0]  rd;
        int          p;
        int          ds_len;
        string       tag;
    } exp_t;

    exp_t       q[$];
    int         checks = 0;
    int         errors = 0;
    int         w_start = 0;
    int         w_len = 0;
    bit         w_noise = 0;
    logic [7:0] rd_val = '0;

    task automatic chk(bit ok, string rq, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
        end
    endtask

    // external bus model: wait stretch and read data
    initial begin
        int idx = 0;
        forever begin
            @(negedge clk);
            if (!bus_ds_n) begin
                bus_wait     = (idx >= w_start) && (idx < w_start + w_len);
                bus_rdata_in = rd_val;
                idx++;
            end else begin
                idx          = 0;
                bus_wait     = w_noise;
                bus_rdata_in = ~rd_val;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        int   ms = 0;
        int   as_c = 0, gap_c = 0, ds_c = 0, end_c = 0;
        bit   bad_oe = 0, bad_wd = 0, bad_ad = 0;
        exp_t cur;
        forever begin
            @(negedge clk);
            if (rst) continue;
            if (!bus_as_n) begin
                if (ms != 1) begin
                    ms = 1; as_c = 0; gap_c = 0; ds_c = 0; end_c = 0;
                    bad_oe = 0; bad_wd = 0; bad_ad = 0;
                    if (q.size() > 0) cur = q[0];
                end
                as_c++;
            end else if (!bus_ds_n) begin
                ms = 3;
                ds_c++;
            end else if (ms == 1 || ms == 2) begin
                ms = 2;
                gap_c++;
            end else if (ms == 3) begin
                ms = 4;
                end_c++;
            end else if (ms == 4 && !ack) begin
                end_c++;
            end
            if (ms == 1 || ms == 2) begin
                if (!bus_addr_oe) bad_oe = 1;
                if (bus_addr != cur.addr || bus_rd != !cur.wr) bad_ad = 1;
            end
            if (ms == 3 && bus_addr_oe != cur.wr) bad_oe = 1;
            if (ms == 4 && !ack && bus_addr_oe) bad_oe = 1;
            if (ms >= 1 && ms <= 4 && !(ms == 4 && ack)) begin
                if (bus_wdata_oe != cur.wr) bad_wd = 1;
                if (cur.wr && bus_wdata != cur.wd) bad_wd = 1;
            end
            if (ack) begin
                if (ms != 4 || q.size() == 0) begin
                    chk(0, "R9 unexpected ack", ms, 4);
                end else begin
                    void'(q.pop_front());
                    chk(as_c == 2 * cur.p + 1, "R2 as length", as_c, 2 * cur.p + 1);
                    chk(bad_ad == 0, "R2 address/direction", bad_ad, 0);
                    chk(gap_c == 1, "R3 as-to-ds gap", gap_c, 1);
                    chk(ds_c == cur.ds_len, cur.tag, ds_c, cur.ds_len);
                    chk(end_c == 1, "R9 ds-to-ack gap", end_c, 1);
                    chk(bad_oe == 0, "R8 address enable", bad_oe, 0);
                    chk(bad_wd == 0, "R5 write data enable", bad_wd, 0);
                    if (!cur.wr)
                        chk(rdata == cur.rd, "R7 read data", rdata, cur.rd);
                end
                ms = 0;
            end
        end
    end

    task automatic bus_op(bit wr, logic [15:0] a, logic [7:0] wd, int p, int w,
                          int ws, int wl, bit noise, bit hold, string tag);
        exp_t e;
        int   ext;
        ext      = (wl > 0 && ws <= 2 * w) ? wl : 0;
        e.wr     = wr;
        e.addr   = a;
        e.wd     = wd;
        e.rd     = a[7:0] ^ 8'h5A;
        e.p      = p;
        e.ds_len = (wr ? (2 * p + 2 * w + 2) : (4 * p + 2 * w + 3)) + ext;
        e.tag    = tag;
        q.push_back(e);
        @(negedge clk);
        w_start   = ws;
        w_len     = wl;
        w_noise   = noise;
        rd_val    = e.rd;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        cfg_pre   = 3'(p);
        cfg_wait  = 3'(w);
        req       = 1'b1;
        while (bus_as_n) @(negedge clk);
        // R10: scramble every request field once the cycle is running
        req_write = ~wr;
        req_addr  = ~a;
        req_wdata = ~wd;
        cfg_pre   = ~3'(p);
        cfg_wait  = ~3'(w);
        while (!ack) @(negedge clk);
        if (hold) begin
            @(negedge clk);
            chk(bus_as_n == 1'b1, "R9 no start on ack edge", bus_as_n, 1);
        end
        req     = 1'b0;
        w_noise = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_as_n && bus_ds_n, "R1 strobes in reset", bus_as_n & bus_ds_n, 1);
        chk(!bus_addr_oe && !bus_wdata_oe && !ack, "R1 enables in reset",
            bus_addr_oe | bus_wdata_oe | ack, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(bus_as_n && bus_ds_n && !bus_addr_oe && !bus_wdata_oe && !ack,
            "R1 idle after reset", bus_as_n & bus_ds_n, 1);

        bus_op(0, 16'h1234, 8'h00, 0, 0, 0, 0, 0, 0, "R4 read ds p0 w0");
        bus_op(1, 16'h4321, 8'hA5, 0, 0, 0, 0, 0, 0, "R5 write ds p0 w0");
        bus_op(0, 16'h0F0F, 8'h00, 3, 2, 0, 0, 0, 0, "R4 read ds p3 w2");
        bus_op(1, 16'hBEEF, 8'h3C, 7, 7, 0, 0, 0, 0, "R5 write ds p7 w7");
        bus_op(0, 16'h2222, 8'h00, 2, 1, 0, 3, 0, 0, "R6 wait at window start");
        bus_op(0, 16'h3333, 8'h00, 1, 2, 4, 2, 0, 0, "R6 wait at window end");
        bus_op(0, 16'h4444, 8'h00, 1, 2, 5, 3, 0, 0, "R6 wait after window ignored");
        bus_op(1, 16'h5555, 8'h96, 2, 3, 3, 4, 1, 0, "R6 write wait with noise");
        bus_op(0, 16'h6666, 8'h00, 1, 1, 0, 0, 0, 1, "R9 held request read");
        bus_op(0, 16'h7777, 8'h00, 7, 7, 14, 1, 1, 0, "R10 read p7 w7 latched");

        repeat (4) @(negedge clk);
        chk(q.size() == 0, "R9 all cycles acknowledged", q.size(), 0);
        chk(bus_as_n && bus_ds_n && !ack, "R1 idle at end", bus_as_n & bus_ds_n, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule